// File: doc/BRIEF.md
# Cascadable True Dual-Port RAM

This block is a 9,216-bit synchronous memory with two fully independent ports. Each port has its own clock, clock enable, write enable, synchronous reset, 3-bit chip select, address, write data and registered read data. Either port may read or write on any of its own clock edges. The two clocks may be unrelated in frequency and phase.

One parameter picks the word shape from a fixed menu. Both ports use the same shape. A second parameter holds the 3-bit code that the instance answers to. Up to eight instances can share one bus: the chip-select lines act as extra address bits above the instance's own address, and only the instance whose code matches takes part in an access.

The port reset clears only that port's output register. The stored words survive any reset.

Top module: `tdp_ram9k`

## Requirements
- R1: `DATA_W` selects the shape. 18 gives 512 words and a 9-bit address. 9 gives 1024 words and a 10-bit address. 4 gives 2048 words and an 11-bit address. 2 gives 4096 words and a 12-bit address. 1 gives 8192 words and a 13-bit address. Any other width stops elaboration. Word 0 and the last word (depth minus 1) are distinct and both usable.
- R2: Port A acts only on rising edges of `clk_a`, and port B acts only on rising edges of `clk_b`. The two clocks may run at unrelated rates. A port's output does not change between its own edges.
- R3: An access is a rising edge at which `ce=1`, `cs` equals `CS_CODE` and `rst=0`. In a read access (`we=0`), `q` shows the word at `addr` after that edge. This is one clock of latency.
- R4: In a write access (`we=1`), `din` is stored at `addr`, and `q` shows `din` after that same edge (write-through).
- R5: A word written by either port is read back by both ports. When both ports write one address at different times, the later write is the one read back.
- R6: A rising edge where `cs` differs from `CS_CODE` performs no write, and the port's `q` keeps its previous value.
- R7: A rising edge where `ce=0` performs no write, and the port's `q` keeps its previous value.
- R8: A rising edge with `rst=1` clears that port's `q` to all zeros and performs no write. Stored words are unchanged by reset.
- R9: Write accesses by the two ports to different addresses in overlapping cycles both take effect. Writes by both ports to the same address at once are not allowed, and the resulting word is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock, rising edge |
| rst_a | input | 1 | Port A synchronous reset of its output register, active high |
| ce_a | input | 1 | Port A clock enable, active high |
| we_a | input | 1 | Port A write enable, active high |
| cs_a | input | 3 | Port A chip select, compared with `CS_CODE` |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| q_a | output | DATA_W | Port A registered read data |
| clk_b | input | 1 | Port B clock, rising edge |
| rst_b | input | 1 | Port B synchronous reset of its output register, active high |
| ce_b | input | 1 | Port B clock enable, active high |
| we_b | input | 1 | Port B write enable, active high |
| cs_b | input | 3 | Port B chip select, compared with `CS_CODE` |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| q_b | output | DATA_W | Port B registered read data |

## Verification
The ownership bits select, for every word, which port's copy of the storage is current. If that selection is stale or inverted, the next read of the word from either port returns the older writer's data. This shows up one clock after the read address is sampled, provided the word has been written by both ports. A wrong chip-select or enable decode shows up in two ways: a write that should have been blocked is later read back, or an output register changes on an edge where it should have held, visible at the very next edge. An address-width error per shape shows up as word 0 being overwritten by a write to the last word.

// File: rtl/tdp_ram9k_pkg.sv
package tdp_ram9k_pkg;

   localparam int unsigned ARRAY_BITS = 9216;
   localparam int unsigned CS_W       = 3;

   // Address width for each supported word width; 0 marks an unsupported width.
   function automatic int unsigned addr_bits(input int unsigned width);
      case (width)
         1:       return 13;
         2:       return 12;
         4:       return 11;
         9:       return 10;
         18:      return 9;
         default: return 0;
      endcase
   endfunction

   function automatic bit shape_ok(input int unsigned width);
      return (addr_bits(width) != 0) &&
             (((32'd1 << addr_bits(width)) * width) <= ARRAY_BITS);
   endfunction

endpackage

// File: rtl/tdp_ram9k_bank.sv
// One storage copy written by a single port, plus that port's
// ownership bits. Read combinationally at both ports' addresses.
module tdp_ram9k_bank #(
   parameter int unsigned DATA_W    = 18,
   parameter int unsigned ADDR_W    = 9,
   parameter bit          STORE_INV = 1'b0
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              peer_live,
   input  logic [ADDR_W-1:0] rd_addr_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [DATA_W-1:0] rd_data_a,
   output logic [DATA_W-1:0] rd_data_b,
   output logic              live_a,
   output logic              live_b
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] word_mem [DEPTH];
   logic              live_mem [DEPTH];
   logic              next_live;

   // The bank that claims a word by equality stores the peer bit as is;
   // the bank that claims by difference stores it inverted.
   generate
      if (STORE_INV) begin : g_claim_diff
         assign next_live = ~peer_live;
      end else begin : g_claim_same
         assign next_live = peer_live;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) begin
         word_mem[wr_addr] <= wr_data;
         live_mem[wr_addr] <= next_live;
      end
   end

   assign rd_data_a = word_mem[rd_addr_a];
   assign rd_data_b = word_mem[rd_addr_b];
   assign live_a    = live_mem[rd_addr_a];
   assign live_b    = live_mem[rd_addr_b];

endmodule

// File: rtl/tdp_ram9k_port.sv
// Per-port access qualification and registered read data.
module tdp_ram9k_port #(
   parameter int unsigned DATA_W  = 18,
   parameter logic [2:0]  CS_CODE = 3'd0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce,
   input  logic              we,
   input  logic [2:0]        cs,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] word_a,
   input  logic [DATA_W-1:0] word_b,
   input  logic              live_a,
   input  logic              live_b,
   output logic              wr_en,
   output logic [DATA_W-1:0] q
);

   logic              hit;
   logic [DATA_W-1:0] rd_word;

   assign hit     = ce && (cs == CS_CODE) && !rst;
   assign wr_en   = hit && we;
   // Equal ownership bits: copy A is current; different: copy B is.
   assign rd_word = (live_a == live_b) ? word_a : word_b;

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (hit) begin
         q <= we ? din : rd_word;
      end
   end

endmodule

// File: rtl/tdp_ram9k.sv
module tdp_ram9k #(
   parameter int unsigned DATA_W  = 18,
   parameter logic [2:0]  CS_CODE = 3'd0,
   localparam int unsigned ADDR_W = tdp_ram9k_pkg::addr_bits(DATA_W)
) (
   input  logic              clk_a,
   input  logic              rst_a,
   input  logic              ce_a,
   input  logic              we_a,
   input  logic [2:0]        cs_a,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [DATA_W-1:0] din_a,
   output logic [DATA_W-1:0] q_a,
   input  logic              clk_b,
   input  logic              rst_b,
   input  logic              ce_b,
   input  logic              we_b,
   input  logic [2:0]        cs_b,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [DATA_W-1:0] din_b,
   output logic [DATA_W-1:0] q_b
);

   localparam int unsigned NPORT = 2;

   // r1: only the listed shapes elaborate
   generate
      if (!tdp_ram9k_pkg::shape_ok(DATA_W)) begin : g_bad_shape
         $error("tdp_ram9k: DATA_W=%0d is not a supported shape", DATA_W);
      end
   endgenerate

   logic              clk_p  [NPORT];
   logic              rst_p  [NPORT];
   logic              ce_p   [NPORT];
   logic              we_p   [NPORT];
   logic [2:0]        cs_p   [NPORT];
   logic [ADDR_W-1:0] addr_p [NPORT];
   logic [DATA_W-1:0] din_p  [NPORT];
   logic [DATA_W-1:0] q_p    [NPORT];
   logic              wr_p   [NPORT];
   // [bank][port whose address selects the entry]
   logic [DATA_W-1:0] word_x [NPORT][NPORT];
   logic              live_x [NPORT][NPORT];

   assign clk_p[0]  = clk_a;   assign clk_p[1]  = clk_b;
   assign rst_p[0]  = rst_a;   assign rst_p[1]  = rst_b;
   assign ce_p[0]   = ce_a;    assign ce_p[1]   = ce_b;
   assign we_p[0]   = we_a;    assign we_p[1]   = we_b;
   assign cs_p[0]   = cs_a;    assign cs_p[1]   = cs_b;
   assign addr_p[0] = addr_a;  assign addr_p[1] = addr_b;
   assign din_p[0]  = din_a;   assign din_p[1]  = din_b;
   assign q_a = q_p[0];
   assign q_b = q_p[1];

   generate
      for (genvar g = 0; g < NPORT; g++) begin : g_lane
         tdp_ram9k_bank #(
            .DATA_W    (DATA_W),
            .ADDR_W    (ADDR_W),
            .STORE_INV (g == 1)
         ) u_bank (
            .clk       (clk_p[g]),
            .wr_en     (wr_p[g]),
            .wr_addr   (addr_p[g]),
            .wr_data   (din_p[g]),
            .peer_live (live_x[NPORT-1-g][g]),
            .rd_addr_a (addr_p[0]),
            .rd_addr_b (addr_p[1]),
            .rd_data_a (word_x[g][0]),
            .rd_data_b (word_x[g][1]),
            .live_a    (live_x[g][0]),
            .live_b    (live_x[g][1])
         );

         tdp_ram9k_port #(
            .DATA_W  (DATA_W),
            .CS_CODE (CS_CODE)
         ) u_port (
            .clk    (clk_p[g]),
            .rst    (rst_p[g]),
            .ce     (ce_p[g]),
            .we     (we_p[g]),
            .cs     (cs_p[g]),
            .din    (din_p[g]),
            .word_a (word_x[0][g]),
            .word_b (word_x[1][g]),
            .live_a (live_x[0][g]),
            .live_b (live_x[1][g]),
            .wr_en  (wr_p[g]),
            .q      (q_p[g])
         );
      end
   endgenerate

endmodule

// File: rtl/tdp_ram9k_chk.sv
module tdp_ram9k_chk #(
   parameter int unsigned DATA_W  = 18,
   parameter int unsigned ADDR_W  = 9,
   parameter logic [2:0]  CS_CODE = 3'd0
) (
   input logic              clk_a,
   input logic              rst_a,
   input logic              ce_a,
   input logic              we_a,
   input logic [2:0]        cs_a,
   input logic [ADDR_W-1:0] addr_a,
   input logic [DATA_W-1:0] din_a,
   input logic [DATA_W-1:0] q_a,
   input logic              clk_b,
   input logic              rst_b,
   input logic              ce_b,
   input logic              we_b,
   input logic [2:0]        cs_b,
   input logic [ADDR_W-1:0] addr_b,
   input logic [DATA_W-1:0] din_b,
   input logic [DATA_W-1:0] q_b
);

   p_wthru_a_r4: assert property (@(posedge clk_a) disable iff (rst_a)
      (ce_a && we_a && cs_a == CS_CODE) |=> (q_a == $past(din_a)));
   p_wthru_b_r4: assert property (@(posedge clk_b) disable iff (rst_b)
      (ce_b && we_b && cs_b == CS_CODE) |=> (q_b == $past(din_b)));

   p_cs_hold_a_r6: assert property (@(posedge clk_a) disable iff (rst_a)
      (cs_a != CS_CODE) |=> $stable(q_a));
   p_cs_hold_b_r6: assert property (@(posedge clk_b) disable iff (rst_b)
      (cs_b != CS_CODE) |=> $stable(q_b));

   p_ce_hold_a_r7: assert property (@(posedge clk_a) disable iff (rst_a)
      !ce_a |=> $stable(q_a));
   p_ce_hold_b_r7: assert property (@(posedge clk_b) disable iff (rst_b)
      !ce_b |=> $stable(q_b));

   p_rst_clear_a_r8: assert property (@(posedge clk_a) disable iff (1'b0)
      rst_a |=> (q_a == '0));
   p_rst_clear_b_r8: assert property (@(posedge clk_b) disable iff (1'b0)
      rst_b |=> (q_b == '0));

   // R9: both ports must never present a write to one word at once
   p_no_collide_r9: assert property (@(posedge clk_a) disable iff (rst_a || rst_b)
      !(ce_a && we_a && cs_a == CS_CODE &&
        ce_b && we_b && cs_b == CS_CODE && addr_a == addr_b));

endmodule

bind tdp_ram9k tdp_ram9k_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .CS_CODE (CS_CODE)
) u_chk (
   .clk_a  (clk_a),  .rst_a (rst_a), .ce_a (ce_a), .we_a (we_a),
   .cs_a   (cs_a),   .addr_a(addr_a), .din_a(din_a), .q_a (q_a),
   .clk_b  (clk_b),  .rst_b (rst_b), .ce_b (ce_b), .we_b (we_b),
   .cs_b   (cs_b),   .addr_b(addr_b), .din_b(din_b), .q_b (q_b)
);

// File: tb/tb_tdp_ram9k.sv
`timescale 1ns/1ps
module tb_tdp_ram9k;
   import tdp_ram9k_pkg::*;

   localparam int CLK_A_PERIOD = 10;
   localparam int CLK_B_PERIOD = 14;
   localparam logic [2:0] CODE = 3'd5;
   localparam int NW = 4;
   localparam int WIDTHS [NW] = '{1, 2, 4, 9};

   logic clk_a = 1'b0, clk_b = 1'b0;
   logic rst_a, ce_a, we_a, rst_b, ce_b, we_b;
   logic [2:0]  cs_a, cs_b;
   logic [12:0] a_addr, b_addr;
   logic [17:0] a_din, b_din;
   logic [17:0] q_a, q_b;
   logic [17:0] qb_n [NW];

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [17:0] mdl [512];

   always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
   always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

   tdp_ram9k #(.DATA_W(18), .CS_CODE(CODE)) dut (
      .clk_a(clk_a), .rst_a(rst_a), .ce_a(ce_a), .we_a(we_a), .cs_a(cs_a),
      .addr_a(a_addr[8:0]), .din_a(a_din), .q_a(q_a),
      .clk_b(clk_b), .rst_b(rst_b), .ce_b(ce_b), .we_b(we_b), .cs_b(cs_b),
      .addr_b(b_addr[8:0]), .din_b(b_din), .q_b(q_b)
   );

   generate
      for (genvar i = 0; i < NW; i++) begin : g_shape
         localparam int W  = WIDTHS[i];
         localparam int AW = addr_bits(W);
         logic [W-1:0] qa_l, qb_l;
         tdp_ram9k #(.DATA_W(W), .CS_CODE(CODE)) dut_n (
            .clk_a(clk_a), .rst_a(rst_a), .ce_a(ce_a), .we_a(we_a), .cs_a(cs_a),
            .addr_a(a_addr[AW-1:0]), .din_a(a_din[W-1:0]), .q_a(qa_l),
            .clk_b(clk_b), .rst_b(rst_b), .ce_b(ce_b), .we_b(we_b), .cs_b(cs_b),
            .addr_b(b_addr[AW-1:0]), .din_b(b_din[W-1:0]), .q_b(qb_l)
         );
         assign qb_n[i] = 18'(qb_l);
      end
   endgenerate

   task automatic chk(input string tag, input logic [17:0] got, input logic [17:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // One port-A edge with the given controls; model follows accepted writes.
   task automatic a_cycle(input logic rst, input logic ce, input logic we,
                          input logic [2:0] cs, input logic [12:0] addr,
                          input logic [17:0] din);
      @(negedge clk_a);
      rst_a = rst; ce_a = ce; we_a = we; cs_a = cs; a_addr = addr; a_din = din;
      @(negedge clk_a);
      if (!rst && ce && we && cs == CODE) mdl[addr[8:0]] = din;
      rst_a = 1'b0; ce_a = 1'b0; we_a = 1'b0;
   endtask

   task automatic b_cycle(input logic rst, input logic ce, input logic we,
                          input logic [2:0] cs, input logic [12:0] addr,
                          input logic [17:0] din);
      @(negedge clk_b);
      rst_b = rst; ce_b = ce; we_b = we; cs_b = cs; b_addr = addr; b_din = din;
      @(negedge clk_b);
      if (!rst && ce && we && cs == CODE) mdl[addr[8:0]] = din;
      rst_b = 1'b0; ce_b = 1'b0; we_b = 1'b0;
   endtask

   task automatic a_wr(input logic [12:0] addr, input logic [17:0] d);
      a_cycle(1'b0, 1'b1, 1'b1, CODE, addr, d);
   endtask
   task automatic b_wr(input logic [12:0] addr, input logic [17:0] d);
      b_cycle(1'b0, 1'b1, 1'b1, CODE, addr, d);
   endtask
   task automatic a_rd(input logic [12:0] addr, input string tag);
      a_cycle(1'b0, 1'b1, 1'b0, CODE, addr, 18'h0);
      chk(tag, q_a, mdl[addr[8:0]]);
   endtask
   task automatic b_rd(input logic [12:0] addr, input string tag);
      b_cycle(1'b0, 1'b1, 1'b0, CODE, addr, 18'h0);
      chk(tag, q_b, mdl[addr[8:0]]);
   endtask

   task automatic t_reset_state;
      chk("R8 reset clears q_a", q_a, 18'h0);
      chk("R8 reset clears q_b", q_b, 18'h0);
   endtask

   task automatic t_write_through;
      a_wr(13'd3, 18'h2A5A5);
      chk("R4 write-through port A", q_a, 18'h2A5A5);
      b_wr(13'd7, 18'h1C3C3);
      chk("R4 write-through port B", q_b, 18'h1C3C3);
   endtask

   task automatic t_latency;
      a_rd(13'd7, "R3 read port A");
      @(negedge clk_a);
      ce_a = 1'b1; we_a = 1'b0; cs_a = CODE; a_addr = 13'd3;
      #(CLK_A_PERIOD/4);
      chk("R3 q_a unchanged before edge", q_a, mdl[7]);
      @(negedge clk_a);
      chk("R3 q_a after one edge", q_a, mdl[3]);
      ce_a = 1'b0;
      b_rd(13'd3, "R2 read port B");
      @(negedge clk_b);
      ce_b = 1'b1; we_b = 1'b0; cs_b = CODE; b_addr = 13'd7;
      #(CLK_B_PERIOD/4);
      chk("R2 q_b holds between own edges", q_b, mdl[3]);
      @(negedge clk_b);
      chk("R2 q_b after own edge", q_b, mdl[7]);
      ce_b = 1'b0;
   endtask

   task automatic t_cross;
      a_wr(13'd20, 18'h00111);
      b_rd(13'd20, "R5 B reads A write");
      b_wr(13'd21, 18'h3F00F);
      a_rd(13'd21, "R5 A reads B write");
      a_wr(13'd30, 18'h12345);
      b_wr(13'd30, 18'h0ABCD);
      a_rd(13'd30, "R5 later B write wins at A");
      a_wr(13'd30, 18'h35555);
      b_rd(13'd30, "R5 later A write wins at B");
   endtask

   task automatic t_concurrent;
      fork
         a_wr(13'd40, 18'h24680);
         b_wr(13'd41, 18'h13579);
      join
      fork
         b_rd(13'd40, "R9 overlapping write A lands");
         a_rd(13'd41, "R9 overlapping write B lands");
      join
   endtask

   task automatic t_cs_mismatch;
      logic [17:0] held;
      a_rd(13'd3, "R6 prime port A");
      held = q_a;
      a_cycle(1'b0, 1'b1, 1'b1, CODE ^ 3'd1, 13'd3, 18'h3FFFF);
      chk("R6 q_a holds on cs mismatch", q_a, held);
      b_rd(13'd3, "R6 no write on cs mismatch");
      held = q_b;
      b_cycle(1'b0, 1'b1, 1'b0, 3'd0, 13'd20, 18'h0);
      chk("R6 q_b holds on cs mismatch read", q_b, held);
   endtask

   task automatic t_ce_low;
      logic [17:0] held;
      held = q_b;
      b_cycle(1'b0, 1'b0, 1'b1, CODE, 13'd7, 18'h00FFF);
      chk("R7 q_b holds with ce low", q_b, held);
      a_rd(13'd7, "R7 no write with ce low");
   endtask

   task automatic t_reset_mid;
      a_wr(13'd50, 18'h2F0F0);
      a_cycle(1'b1, 1'b1, 1'b1, CODE, 13'd50, 18'h01234);
      chk("R8 reset mid-sequence clears q_a", q_a, 18'h0);
      b_rd(13'd50, "R8 no write during reset");
      a_rd(13'd50, "R8 array kept after reset");
   endtask

   task automatic t_bounds;
      a_wr(13'd0, 18'h0F00F);
      b_wr(13'd511, 18'h30F0F);
      a_rd(13'd511, "R1 last word 18-bit shape");
      b_rd(13'd0, "R1 word 0 18-bit shape");
   endtask

   task automatic t_aspect;
      for (int i = 0; i < NW; i++) begin
         int w = WIDTHS[i];
         logic [17:0] mask = 18'((32'd1 << w) - 1);
         logic [12:0] last = 13'((32'd1 << addr_bits(w)) - 1);
         logic [17:0] p0 = 18'h2AAAA ^ 18'(i);
         logic [17:0] p1 = 18'h15555 ^ 18'(i * 3);
         a_wr(13'd0, p0);
         a_wr(last, p1);
         b_cycle(1'b0, 1'b1, 1'b0, CODE, 13'd0, 18'h0);
         chk($sformatf("R1 width %0d word 0", w), qb_n[i], p0 & mask);
         b_cycle(1'b0, 1'b1, 1'b0, CODE, last, 18'h0);
         chk($sformatf("R1 width %0d last word", w), qb_n[i], p1 & mask);
      end
   endtask

   initial begin
      rst_a = 1'b1; rst_b = 1'b1; ce_a = 1'b0; ce_b = 1'b0; we_a = 1'b0; we_b = 1'b0;
      cs_a = CODE; cs_b = CODE; a_addr = '0; b_addr = '0; a_din = '0; b_din = '0;
      repeat (3) @(negedge clk_b);
      rst_a = 1'b0; rst_b = 1'b0;
      t_reset_state();
      t_write_through();
      t_latency();
      t_cross();
      t_concurrent();
      t_cs_mismatch();
      t_ce_low();
      t_reset_mid();
      t_bounds();
      t_aspect();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_A_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule